// File: doc/BRIEF.md
# Serial-Attached Calendar Clock Register Slave

This block is a real-time clock that a host reaches over a four-wire serial link (clock idles low, data sampled on the rising edge, 8-bit words, most significant bit first). Each transaction opens with an opcode byte and an address byte. Two opcodes are recognised: one streams register bytes back to the host, the other stores the bytes that follow. The address steps forward after every data byte, so a single transaction can read or set the whole calendar.

The clock keeps seconds, minutes, hours, weekday, date, month and a two-digit year as BCD fields, plus a leap flag, an oscillator start bit, an oscillator-running status flag, a 12/24-hour select bit and a control byte. A free-running `sub_tick` enable stands in for the crystal. While the start bit is set, `sub_tick` pulses are divided by `PRESCALE` into one-second steps, and each step ripples through the calendar.

The serial pins are sampled into the system clock domain, which must run much faster than the serial clock.

Top module: `spi_clock_regs`

## Requirements
- R1: Opcode 0x13 followed by an address byte makes the block shift the register at that address out on `spi_miso`, MSB first, for each further byte while `spi_cs_n` stays low. `spi_miso` is 0 during the opcode and address bytes and while `spi_cs_n` is high.
- R2: Opcode 0x12 followed by an address byte stores each complete 8-bit data byte. A byte cut short by `spi_cs_n` rising is discarded.
- R3: The 5-bit address advances after every data byte in both directions and wraps from 0x1F to 0x00. Address 0x00 and addresses 0x09 to 0x1F read as 0x00 and ignore writes.
- R4: Any other opcode is ignored until `spi_cs_n` goes high. `spi_miso` stays 0 and no register changes.
- R5: Register layout:
  - 0x01 is {start, seconds[6:0]}.
  - 0x02 is minutes in bits 6:0.
  - 0x03 is {12h-mode, hours[5:0]}, where bit 5 is PM in 12-hour mode.
  - 0x04 is weekday 1..7 in bits 2:0.
  - 0x05 is date in bits 5:0.
  - 0x06 is {leap, month[4:0]} in bits 5:0.
  - 0x07 is the year.
  - 0x08 is a full 8-bit control byte, with bit 3 selecting the external oscillator.

  Bits outside these fields read as 0. After reset, weekday, date and month read 0x01 and every other register reads 0x00.
- R6: The time fields advance once per `PRESCALE` `sub_tick` pulses, and only while the start bit (0x01 bit 7) is 1.
- R7: Bit 5 of 0x04 is a read-only oscillator-running flag. It becomes 1 exactly `ON_DELAY` `sub_tick` pulses after the start bit is set, and becomes 0 exactly `OFF_DELAY` pulses after the start bit is cleared.
- R8: In 24-hour mode, seconds roll 59 to 00 and carry into minutes, minutes roll 59 to 00 and carry into hours, and hours roll 23 to 00 and carry into the date.
- R9: In 12-hour mode, 11 toggles the PM bit on its way to 12, and 12 goes to 01 with PM unchanged. The date advances only at 11 PM to 12 AM.
- R10: The date rolls over to 01 after the last day of the month: 30 for April, June, September and November, 28 for February (29 with the leap flag set), and 31 otherwise. The weekday steps 7 to 1 on each date carry. The month rolls 12 to 01 and carries into the year, and the year rolls 99 to 00.
- R11: A write to any register from 0x01 to 0x07 clears the sub-second prescaler, so the next second takes a full `PRESCALE` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | One-cycle enable pulse from the timebase; `PRESCALE` of them make one second |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select that frames a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The assertions assume the serial clock is slow enough that each of its levels spans several system clocks. They also assume chip select changes only while the serial clock is low. Given those conditions, every serial edge is seen exactly once after synchronisation. The bench holds each serial level for five system clocks and only toggles chip select with the serial clock low. It issues `sub_tick` pulses only between transactions, so no second boundary lands inside a read burst, and the sampled calendar matches the bench model exactly.

// File: rtl/spi_clock_regs.sv
module spi_clock_regs #(
  parameter int PRESCALE  = 32768,
  parameter int ON_DELAY  = 4,
  parameter int OFF_DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int PW   = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int DMAX = (ON_DELAY > OFF_DELAY) ? ON_DELAY : OFF_DELAY;
  localparam int DW   = $clog2(DMAX + 1);

  typedef enum logic [2:0] {P_OPC, P_ADR, P_RD, P_WR, P_IGN} phase_t;

  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] hi, input logic [7:0] lo);
    if (v == hi)           return lo;
    else if (v[3:0] >= 9)  return {v[7:4] + 4'd1, 4'h0};
    else                   return v + 8'd1;
  endfunction

  // serial pin synchronisers
  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0; cs_q <= 2'b11; mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  logic cs_s, mosi_s, sclk_rise, sclk_fall;
  assign cs_s      = cs_q[1];
  assign mosi_s    = mosi_q[1];
  assign sclk_rise =  sclk_q[1] & ~sclk_q[2];
  assign sclk_fall = ~sclk_q[1] &  sclk_q[2];

  // frame state
  phase_t     phase;
  logic       op_rd;
  logic [2:0] bitcnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr, rx_byte, rd_data;
  logic [4:0] addr;
  logic       byte_done, wr_stb, wr_time;

  assign rx_byte   = {rx_sr, mosi_s};
  assign byte_done = ~cs_s & sclk_rise & (bitcnt == 3'd7);
  assign wr_stb    = byte_done & (phase == P_WR);
  assign wr_time   = wr_stb & (addr >= 5'd1) & (addr <= 5'd7);
  assign spi_miso  = ~cs_s & (phase == P_RD) & tx_sr[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_OPC; op_rd <= 1'b0; bitcnt <= '0; rx_sr <= '0; tx_sr <= '0; addr <= '0;
    end else if (cs_s) begin
      phase <= P_OPC; bitcnt <= '0; tx_sr <= '0;
    end else begin
      if (sclk_rise) begin
        rx_sr  <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7)
          case (phase)
            P_OPC: begin
              op_rd <= (rx_byte == 8'h13);
              phase <= (rx_byte == 8'h13 || rx_byte == 8'h12) ? P_ADR : P_IGN;
            end
            P_ADR: begin
              addr  <= rx_byte[4:0];
              phase <= op_rd ? P_RD : P_WR;
            end
            P_RD, P_WR: addr <= addr + 5'd1;
            default: ;
          endcase
      end
      if (sclk_fall && phase == P_RD)
        tx_sr <= (bitcnt == 3'd0) ? rd_data : {tx_sr[6:0], 1'b0};
    end

  // calendar registers
  logic       st, osc_run, leap;
  logic [6:0] sec, min, hour;
  logic [2:0] wday;
  logic [5:0] date;
  logic [4:0] mon;
  logic [7:0] year, ctrl;

  always_comb
    case (addr)
      5'd1:    rd_data = {st, sec};
      5'd2:    rd_data = {1'b0, min};
      5'd3:    rd_data = {1'b0, hour};
      5'd4:    rd_data = {2'b00, osc_run, 2'b00, wday};
      5'd5:    rd_data = {2'b00, date};
      5'd6:    rd_data = {2'b00, leap, mon};
      5'd7:    rd_data = year;
      5'd8:    rd_data = ctrl;
      default: rd_data = 8'h00;
    endcase

  // prescaler
  logic [PW-1:0] presc;
  logic          sec_tick;
  assign sec_tick = st & sub_tick & (presc == PW'(PRESCALE - 1)) & ~wr_time;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                presc <= '0;
    else if (wr_time)          presc <= '0;
    else if (st && sub_tick)   presc <= (presc == PW'(PRESCALE - 1)) ? '0 : presc + PW'(1);

  // carry chain
  logic [7:0] sec_nx, min_nx, h24_nx, h12_nx, date_nx, year_nx, mon_nx, last_day;
  logic [6:0] hour_nx;
  logic       c_min, c_hour, c_day, c_mon, c_year;

  assign sec_nx  = bcd_next({1'b0, sec}, 8'h59, 8'h00);
  assign min_nx  = bcd_next({1'b0, min}, 8'h59, 8'h00);
  assign h24_nx  = bcd_next({2'b00, hour[5:0]}, 8'h23, 8'h00);
  assign h12_nx  = bcd_next({3'b000, hour[4:0]}, 8'h12, 8'h01);
  assign date_nx = bcd_next({2'b00, date}, last_day, 8'h01);
  assign mon_nx  = bcd_next({3'b000, mon}, 8'h12, 8'h01);
  assign year_nx = bcd_next(year, 8'h99, 8'h00);

  assign c_min  = (sec == 7'h59);
  assign c_hour = c_min & (min == 7'h59);
  assign c_mon  = c_day & ({2'b00, date} == last_day);
  assign c_year = c_mon & (mon == 5'h12);

  always_comb begin
    if (hour[6]) begin
      c_day = c_hour & hour[5] & (hour[4:0] == 5'h11);
      if (hour[4:0] == 5'h11) hour_nx = {1'b1, ~hour[5], 5'h12};
      else                    hour_nx = {1'b1, hour[5], h12_nx[4:0]};
    end else begin
      c_day   = c_hour & (hour[5:0] == 6'h23);
      hour_nx = {1'b0, h24_nx[5:0]};
    end
  end

  always_comb
    case (mon)
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= 1'b0; sec <= '0; min <= '0; hour <= '0; wday <= 3'd1;
      date <= 6'h01; mon <= 5'h01; leap <= 1'b0; year <= '0; ctrl <= '0;
    end else begin
      if (sec_tick) begin
        sec <= sec_nx[6:0];
        if (c_min)  min  <= min_nx[6:0];
        if (c_hour) hour <= hour_nx;
        if (c_day) begin
          wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
          date <= date_nx[5:0];
        end
        if (c_mon)  mon  <= mon_nx[4:0];
        if (c_year) year <= year_nx;
      end
      if (wr_stb)
        case (addr)
          5'd1: {st, sec}   <= rx_byte;
          5'd2: min         <= rx_byte[6:0];
          5'd3: hour        <= rx_byte[6:0];
          5'd4: wday        <= rx_byte[2:0];
          5'd5: date        <= rx_byte[5:0];
          5'd6: {leap, mon} <= rx_byte[5:0];
          5'd7: year        <= rx_byte;
          5'd8: ctrl        <= rx_byte;
          default: ;
        endcase
    end

  // oscillator-running flag
  logic [DW-1:0] dcnt;
  logic          dlast;
  assign dlast = osc_run ? (dcnt == DW'(OFF_DELAY - 1)) : (dcnt == DW'(ON_DELAY - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcnt <= '0; osc_run <= 1'b0;
    end else if (st == osc_run) begin
      dcnt <= '0;
    end else if (sub_tick) begin
      if (dlast) begin
        osc_run <= st; dcnt <= '0;
      end else begin
        dcnt <= dcnt + DW'(1);
      end
    end

  assert_miso_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !spi_miso);
  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st && !wr_stb) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(date) && $stable(year)));
  assert_run_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_run) |-> $past(st));
  assert_run_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_run) |-> !$past(st));
  assert_sec_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec == 7'h59) |=> (sec == 7'h00));
  assert_presc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> (presc == '0));
endmodule

// File: tb/spi_clock_regs_tb_top.sv
module spi_clock_regs_tb_top;
  localparam int PRE = 16, OND = 4, OFFD = 8, HALF = 5;

  logic clk = 0, rst_n = 0, sub_tick = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso;
  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  logic [7:0] hdr0, hdr1;
  int m_sec, m_min, m_hour, m_wday, m_date, m_mon, m_leap, m_year;

  always #2 clk = ~clk;

  spi_clock_regs #(.PRESCALE(PRE), .ON_DELAY(OND), .OFF_DELAY(OFFD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic int days_in(input int mo, input int lp);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin
          m_hour = 0; m_wday = m_wday % 7 + 1; m_date++;
          if (m_date > days_in(m_mon, m_leap)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic xfer(input logic [7:0] d, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic cs_lo(); cs_n = 0; repeat (HALF) @(negedge clk); endtask
  task automatic cs_hi(); repeat (HALF) @(negedge clk); cs_n = 1; repeat (HALF + 4) @(negedge clk); endtask

  task automatic wr_burst(input logic [7:0] a, input int n);
    logic [7:0] r;
    cs_lo(); xfer(8'h12, 8, r); xfer(a, 8, r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], 8, r);
    cs_hi();
  endtask

  task automatic rd_burst(input logic [7:0] a, input int n);
    logic [7:0] r;
    cs_lo(); xfer(8'h13, 8, r); hdr0 = r; xfer(a, 8, r); hdr1 = r;
    for (int i = 0; i < n; i++) begin xfer(8'h00, 8, r); rbuf[i] = r; end
    cs_hi();
  endtask

  task automatic pulses(input int n);
    repeat (n) begin @(negedge clk) sub_tick = 1; @(negedge clk) sub_tick = 0; end
  endtask

  task automatic set_time();
    wbuf[0] = 8'h80 | bcd(m_sec); wbuf[1] = bcd(m_min); wbuf[2] = bcd(m_hour);
    wbuf[3] = 8'(m_wday); wbuf[4] = bcd(m_date);
    wbuf[5] = 8'(m_leap << 5) | bcd(m_mon); wbuf[6] = bcd(m_year);
    wr_burst(8'h01, 7);
  endtask

  task automatic check_time(input string req);
    rd_burst(8'h01, 7);
    chk({req, " sec"},  rbuf[0], 8'h80 | bcd(m_sec));
    chk({req, " min"},  rbuf[1], bcd(m_min));
    chk({req, " hour"}, rbuf[2], bcd(m_hour));
    chk({req, " wday"}, rbuf[3] & 8'h07, 8'(m_wday));
    chk({req, " date"}, rbuf[4], bcd(m_date));
    chk({req, " mon"},  rbuf[5], 8'(m_leap << 5) | bcd(m_mon));
    chk({req, " year"}, rbuf[6], bcd(m_year));
  endtask

  task automatic roll_case(input int s, input int mi, input int h, input int wd,
                           input int d, input int mo, input int lp, input int y, input string req);
    m_sec = s; m_min = mi; m_hour = h; m_wday = wd; m_date = d; m_mon = mo; m_leap = lp; m_year = y;
    set_time(); pulses(PRE); model_step(); check_time(req);
  endtask

  task automatic h12_case(input logic [7:0] hin, input logic [7:0] hexp, input logic [7:0] dexp);
    wbuf[0] = 8'hD9; wbuf[1] = 8'h59; wbuf[2] = hin; wbuf[3] = 8'h02;
    wbuf[4] = 8'h15; wbuf[5] = 8'h03; wbuf[6] = 8'h24;
    wr_burst(8'h01, 7); pulses(PRE); rd_burst(8'h01, 7);
    chk("R9 12h hour", rbuf[2], hexp);
    chk("R9 12h date", rbuf[4], dexp);
    chk("R9 12h min", rbuf[1], 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all) actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r, r2, r3;
    logic [7:0] rst_exp [9];
    int unsigned seed;
    rst_exp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    seed = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R5 reset layout, R1 header bytes quiet
    rd_burst(8'h00, 9);
    for (int i = 0; i < 9; i++) chk("R5 reset value", rbuf[i], rst_exp[i]);
    chk("R1 miso during opcode", hdr0, 8'h00);
    chk("R1 miso during address", hdr1, 8'h00);

    // R6 stopped clock ignores sub_tick
    pulses(2 * PRE);
    rd_burst(8'h01, 1);
    chk("R6 stopped seconds", rbuf[0], 8'h00);

    // R5 control byte, R3 unmapped address
    wbuf[0] = 8'hA5; wr_burst(8'h08, 1); rd_burst(8'h08, 1);
    chk("R5 control byte", rbuf[0], 8'hA5);
    wbuf[0] = 8'hFF; wr_burst(8'h10, 1); rd_burst(8'h10, 1);
    chk("R3 unmapped reads zero", rbuf[0], 8'h00);

    // R2 partial byte discarded
    cs_lo(); xfer(8'h12, 8, r); xfer(8'h07, 8, r); xfer(8'hFF, 4, r); cs_hi();
    rd_burst(8'h07, 1);
    chk("R2 partial byte", rbuf[0], 8'h00);

    // R4 unknown opcode
    cs_lo(); xfer(8'h55, 8, r); xfer(8'h07, 8, r2); xfer(8'h99, 8, r3); cs_hi();
    chk("R4 miso quiet", r | r2 | r3, 8'h00);
    rd_burst(8'h07, 1);
    chk("R4 year untouched", rbuf[0], 8'h00);

    // R3 address wrap, both directions
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h05; wr_burst(8'h1F, 3);
    rd_burst(8'h1F, 3);
    chk("R3 wrap read 1F", rbuf[0], 8'h00);
    chk("R3 wrap read 00", rbuf[1], 8'h00);
    chk("R3 wrap write into 01", rbuf[2], 8'h05);

    // R7 oscillator-running flag
    wbuf[0] = 8'h80; wr_burst(8'h01, 1);
    rd_burst(8'h04, 1); chk("R7 flag before start delay", rbuf[0] & 8'h20, 8'h00);
    pulses(OND - 1);
    rd_burst(8'h04, 1); chk("R7 flag one short of on delay", rbuf[0] & 8'h20, 8'h00);
    pulses(1);
    rd_burst(8'h04, 1); chk("R7 flag on", rbuf[0] & 8'h20, 8'h20);
    wbuf[0] = 8'h00; wr_burst(8'h01, 1);
    pulses(OFFD - 1);
    rd_burst(8'h04, 1); chk("R7 flag held during off delay", rbuf[0] & 8'h20, 8'h20);
    pulses(1);
    rd_burst(8'h04, 1); chk("R7 flag off", rbuf[0] & 8'h20, 8'h00);
    wbuf[0] = 8'hFF; wr_burst(8'h04, 1);
    rd_burst(8'h04, 1); chk("R7 flag read-only", rbuf[0], 8'h07);

    // R6 running, R11 prescaler clear
    m_sec = 10; m_min = 20; m_hour = 5; m_wday = 3; m_date = 12; m_mon = 6; m_leap = 0; m_year = 24;
    set_time(); pulses(PRE); model_step(); check_time("R6 one second");
    pulses(PRE - 3);
    wbuf[0] = bcd(m_min); wr_burst(8'h02, 1);
    pulses(PRE - 1); check_time("R11 no tick after clear");
    pulses(1); model_step(); check_time("R11 full period");

    // R8 / R10 directed rollovers
    roll_case(59, 59, 23, 7, 31, 12, 0, 99, "R10 year wrap R8");
    roll_case(59, 59, 23, 2, 28, 2, 0, 23, "R10 february");
    roll_case(59, 59, 23, 2, 28, 2, 1, 24, "R10 leap 28");
    roll_case(59, 59, 23, 3, 29, 2, 1, 24, "R10 leap 29");
    roll_case(59, 59, 23, 4, 30, 4, 0, 24, "R10 april");
    roll_case(59, 59, 23, 5, 31, 1, 0, 24, "R10 january");
    roll_case(59, 59, 9, 5, 10, 8, 0, 24, "R8 hour bcd carry");

    // R9 12-hour mode
    h12_case(8'h71, 8'h52, 8'h16);
    h12_case(8'h52, 8'h41, 8'h15);
    h12_case(8'h51, 8'h72, 8'h15);

    // random near-boundary times
    for (int it = 0; it < 30; it++) begin
      int n;
      m_sec  = 50 + $urandom_range(0, 9);
      m_min  = $urandom_range(0, 1) ? 59 : $urandom_range(0, 59);
      m_hour = $urandom_range(0, 1) ? 23 : $urandom_range(0, 23);
      m_mon  = $urandom_range(1, 12);
      m_leap = $urandom_range(0, 1);
      m_date = $urandom_range(0, 1) ? days_in(m_mon, m_leap) : $urandom_range(1, days_in(m_mon, m_leap));
      m_year = $urandom_range(0, 3) == 0 ? 99 : $urandom_range(0, 99);
      m_wday = $urandom_range(1, 7);
      n = $urandom_range(1, 12);
      set_time();
      pulses(n * PRE);
      repeat (n) model_step();
      check_time("R8 R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule